// File: doc/BRIEF.md
# Command-Sequence Store/Recall Controller

This block sits beside a battery-free static memory. It decides when the memory contents are copied into nonvolatile cells (a store) and when they are copied back (a recall). It watches the memory access strobes for a fixed, ordered key of five read addresses. A sixth read then names one of four commands: store, recall, disable automatic store, or enable automatic store. Any write, or any read that is not the next key word, ends a partial key and no command is issued.

A store can also start in two other ways. An external request line can ask for one, and a falling supply can trigger one when automatic store is enabled. Both of these are filtered by a dirty flag, which records whether any write was accepted since the last completed store or recall. A store from the key always runs. While a store or recall is in progress, all memory accesses are blocked. The busy output is held low for the whole store. After a store, the block stays blocked until the external request line is released.

The nonvolatile array and the supply sensing are not part of this block. Each cycle is timed by a counter of a fixed number of clock cycles, and the block issues a one-cycle start pulse to the storage engine.

Top module: `nv_cmd_sequencer`

## Requirements
- R1: While reset is asserted, the outputs are idle: accessBlock=0, busyN=1, storeGo=0, recallGo=0, and autoStoreEn equals AUTO_EN_INIT (default 1). The first clock edge after reset release starts a recall. recallGo is high for one cycle, and accessBlock stays high for exactly RECALL_CYC cycles.
- R2: The key is five reads in order at 4E38, B1C7, 83E0, 7C1F and 703F (hex), with wrStb low. A sixth read then selects the command. 8FC0 starts a store: storeGo pulses and busyN is low for exactly STORE_CYC cycles. 4C63 starts a recall: recallGo pulses and busyN stays high. storeGo and recallGo are never high together.
- R3: A write, or a read at an address that is not the next key word, aborts a partial key, and no command follows. A read at 4E38 that aborts a run counts as the first step of a new run.
- R4: Only addr[15:0] takes part in key matching. addr[16] has no effect.
- R5: A store started by the key runs even when no write has occurred since the last store or recall.
- R6: While hwReqN is low, wrInhibit is high and writes are ignored. If a write is pending, hwReqN low starts a store. After that store, accessBlock stays high until hwReqN is sampled high.
- R7: While a store or recall runs, accessBlock and wrInhibit are high. Writes issued during that time are not recorded.
- R8: While supplyOk is low, wrInhibit is high and hwReqN is ignored. If a write is pending and automatic store is enabled, a store starts. A recall runs once supplyOk returns high.
- R9: Key command 8B45 clears autoStoreEn, and 4B46 sets it. The value is kept through a low-supply period. With autoStoreEn=0, a low supply starts no store.
- R10: A completed store or recall clears the pending-write flag. A later hwReqN request then starts no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W (17) | Access address |
| rdStb | input | 1 | Read access this cycle |
| wrStb | input | 1 | Write access this cycle (takes precedence over rdStb) |
| supplyOk | input | 1 | Supply above switch threshold |
| hwReqN | input | 1 | External store request line, active low |
| busyN | output | 1 | Low while a store runs |
| accessBlock | output | 1 | Memory reads and writes disabled |
| wrInhibit | output | 1 | Memory writes disabled this cycle |
| storeGo | output | 1 | One-cycle store start pulse to the storage engine |
| recallGo | output | 1 | One-cycle recall start pulse to the storage engine |
| autoStoreEn | output | 1 | Automatic store on low supply enabled |

## Verification
Some properties hold on every cycle, and the assertions check them there. A low busy output always comes with blocked access. Writes are inhibited whenever the supply is low or the request line is low. A falling busy output always comes with a store pulse. Recalls never drive busy, the two start pulses never coincide, and access stays blocked after a store that ended while the request line was low. Other behaviour is visible only over a run of accesses, so only the bench scenarios can show it. This covers the ordered key and its abort and restart rules, the exact cycle lengths, and the dirty-flag filtering of hardware and low-supply stores. The bench shows the dirty filter by sending a later request that must start no store. The persistence of the automatic-store setting across a supply dip is also shown only by the bench.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

  localparam int KEY_LEN = 5;

  // Ordered unlock words; the order is behaviour.
  function automatic logic [15:0] keyWord(input int idx);
    case (idx)
      0:       keyWord = 16'h4E38;
      1:       keyWord = 16'hB1C7;
      2:       keyWord = 16'h83E0;
      3:       keyWord = 16'h7C1F;
      4:       keyWord = 16'h703F;
      default: keyWord = 16'h0000;
    endcase
  endfunction

  localparam logic [15:0] OP_STORE    = 16'h8FC0;
  localparam logic [15:0] OP_RECALL   = 16'h4C63;
  localparam logic [15:0] OP_AUTO_OFF = 16'h8B45;
  localparam logic [15:0] OP_AUTO_ON  = 16'h4B46;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_STORE, CMD_RECALL, CMD_AUTO_OFF, CMD_AUTO_ON
  } swCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE, ST_STORE, ST_RECALL, ST_HOLD
  } nvState_t;

  typedef struct packed {
    logic matchEn;
    logic loadStore;
    logic loadRecall;
    logic clrDirty;
  } ctlStrobe_t;

endpackage

// File: rtl/nvseq_datapath.sv
module nvseq_datapath
  import nvseq_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int MATCH_W      = 16,
  parameter int STORE_CYC    = 16,
  parameter int RECALL_CYC   = 10,
  parameter bit AUTO_EN_INIT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic              wrAllowed,
  input  ctlStrobe_t        strobe,
  output swCmd_t            swCmd,
  output logic              dirty,
  output logic              timerZero,
  output logic              autoEn
);

  localparam int SW   = $clog2(KEY_LEN + 1);
  localparam int MAXC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [ADDR_W-1:0] MATCH_MASK = ADDR_W'((64'd1 << MATCH_W) - 1);

  logic [ADDR_W-1:0] maskedAddr;
  logic [KEY_LEN-1:0] keyHit;
  logic [SW-1:0] step;
  logic stepHit;
  logic readOnly;
  logic [TW-1:0] timer;

  assign maskedAddr = addr & MATCH_MASK;
  assign readOnly   = rdStb && !wrStb;

  generate
    for (genvar i = 0; i < KEY_LEN; i++) begin : g_keyCmp
      assign keyHit[i] = (maskedAddr == ADDR_W'(keyWord(i)));
    end
  endgenerate

  always_comb begin
    stepHit = 1'b0;
    for (int i = 0; i < KEY_LEN; i++) begin
      if (step == SW'(i)) stepHit = keyHit[i];
    end
  end

  always_comb begin
    swCmd = CMD_NONE;
    if (strobe.matchEn && readOnly && step == SW'(KEY_LEN)) begin
      if (maskedAddr == ADDR_W'(OP_STORE))         swCmd = CMD_STORE;
      else if (maskedAddr == ADDR_W'(OP_RECALL))   swCmd = CMD_RECALL;
      else if (maskedAddr == ADDR_W'(OP_AUTO_OFF)) swCmd = CMD_AUTO_OFF;
      else if (maskedAddr == ADDR_W'(OP_AUTO_ON))  swCmd = CMD_AUTO_ON;
    end
  end

  // Key step counter: advance on the expected word, restart on anything else.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step <= '0;
    end else if (!strobe.matchEn || wrStb) begin
      step <= '0;
    end else if (rdStb) begin
      if (step != SW'(KEY_LEN) && stepHit) step <= step + SW'(1);
      else if (keyHit[0])                  step <= SW'(1);
      else                                 step <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobe.loadStore) begin
      timer <= TW'(STORE_CYC - 1);
    end else if (strobe.loadRecall) begin
      timer <= TW'(RECALL_CYC - 1);
    end else if (timer != '0) begin
      timer <= timer - TW'(1);
    end
  end

  assign timerZero = (timer == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirty <= 1'b0;
    end else if (strobe.clrDirty) begin
      dirty <= 1'b0;
    end else if (wrStb && wrAllowed) begin
      dirty <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoEn <= AUTO_EN_INIT;
    end else if (swCmd == CMD_AUTO_OFF) begin
      autoEn <= 1'b0;
    end else if (swCmd == CMD_AUTO_ON) begin
      autoEn <= 1'b1;
    end
  end

endmodule

// File: rtl/nvseq_ctrl.sv
module nvseq_ctrl
  import nvseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       hwReqN,
  input  swCmd_t     swCmd,
  input  logic       dirty,
  input  logic       timerZero,
  input  logic       autoEn,
  output ctlStrobe_t strobe,
  output logic       wrAllowed,
  output logic       accessBlock,
  output logic       busyN,
  output logic       storeGo,
  output logic       recallGo
);

  nvState_t state, nextState;
  logic recallPending;

  always_comb begin
    nextState      = state;
    strobe         = '0;
    strobe.matchEn = (state == ST_IDLE) && supplyOk;
    unique case (state)
      ST_IDLE: begin
        if (!supplyOk && autoEn && dirty)       nextState = ST_STORE;
        else if (supplyOk && !hwReqN && dirty)  nextState = ST_STORE;
        else if (swCmd == CMD_STORE)            nextState = ST_STORE;
        else if (swCmd == CMD_RECALL)           nextState = ST_RECALL;
        else if (supplyOk && recallPending)     nextState = ST_RECALL;
      end
      ST_STORE: begin
        if (timerZero) begin
          strobe.clrDirty = 1'b1;
          nextState = hwReqN ? ST_IDLE : ST_HOLD;
        end
      end
      ST_RECALL: begin
        if (timerZero) begin
          strobe.clrDirty = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (hwReqN) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
    strobe.loadStore  = (state == ST_IDLE) && (nextState == ST_STORE);
    strobe.loadRecall = (state == ST_IDLE) && (nextState == ST_RECALL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      storeGo       <= 1'b0;
      recallGo      <= 1'b0;
      recallPending <= 1'b1;
    end else begin
      state    <= nextState;
      storeGo  <= strobe.loadStore;
      recallGo <= strobe.loadRecall;
      if (!supplyOk)              recallPending <= 1'b1;
      else if (strobe.loadRecall) recallPending <= 1'b0;
    end
  end

  assign accessBlock = (state != ST_IDLE);
  assign busyN       = (state != ST_STORE);
  assign wrAllowed   = (state == ST_IDLE) && supplyOk && hwReqN;

endmodule

// File: rtl/nv_cmd_sequencer.sv
module nv_cmd_sequencer
  import nvseq_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int STORE_CYC    = 16,
  parameter int RECALL_CYC   = 10,
  parameter bit AUTO_EN_INIT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic              supplyOk,
  input  logic              hwReqN,
  output logic              busyN,
  output logic              accessBlock,
  output logic              wrInhibit,
  output logic              storeGo,
  output logic              recallGo,
  output logic              autoStoreEn
);

  ctlStrobe_t strobe;
  swCmd_t     swCmd;
  logic       dirty;
  logic       timerZero;
  logic       wrAllowed;

  nvseq_datapath #(
    .ADDR_W      (ADDR_W),
    .MATCH_W     (16),
    .STORE_CYC   (STORE_CYC),
    .RECALL_CYC  (RECALL_CYC),
    .AUTO_EN_INIT(AUTO_EN_INIT)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .rdStb    (rdStb),
    .wrStb    (wrStb),
    .wrAllowed(wrAllowed),
    .strobe   (strobe),
    .swCmd    (swCmd),
    .dirty    (dirty),
    .timerZero(timerZero),
    .autoEn   (autoStoreEn)
  );

  nvseq_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .supplyOk   (supplyOk),
    .hwReqN     (hwReqN),
    .swCmd      (swCmd),
    .dirty      (dirty),
    .timerZero  (timerZero),
    .autoEn     (autoStoreEn),
    .strobe     (strobe),
    .wrAllowed  (wrAllowed),
    .accessBlock(accessBlock),
    .busyN      (busyN),
    .storeGo    (storeGo),
    .recallGo   (recallGo)
  );

  assign wrInhibit = !wrAllowed;

endmodule

// File: rtl/nv_cmd_sequencer_chk.sv
module nv_cmd_sequencer_chk (
  input logic clk,
  input logic rstN,
  input logic supplyOk,
  input logic hwReqN,
  input logic busyN,
  input logic accessBlock,
  input logic wrInhibit,
  input logic storeGo,
  input logic recallGo
);

  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busyN |-> accessBlock);

  assert_low_supply_no_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |-> wrInhibit);

  assert_req_line_no_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    !hwReqN |-> wrInhibit);

  assert_store_start_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyN) |-> storeGo);

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({storeGo, recallGo}));

  assert_recall_not_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    recallGo |-> busyN);

  assert_hold_after_store_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busyN) && !$past(hwReqN)) |-> accessBlock);

endmodule

bind nv_cmd_sequencer nv_cmd_sequencer_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .supplyOk   (supplyOk),
  .hwReqN     (hwReqN),
  .busyN      (busyN),
  .accessBlock(accessBlock),
  .wrInhibit  (wrInhibit),
  .storeGo    (storeGo),
  .recallGo   (recallGo)
);

// File: tb/test_nv_cmd_sequencer.sv
`timescale 1ns/1ps
module test_nv_cmd_sequencer;

  localparam int STORE_CYC  = 16;
  localparam int RECALL_CYC = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [16:0] addr = '0;
  logic rdStb = 1'b0;
  logic wrStb = 1'b0;
  logic supplyOk = 1'b1;
  logic hwReqN = 1'b1;
  logic busyN, accessBlock, wrInhibit, storeGo, recallGo, autoStoreEn;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nv_cmd_sequencer #(
    .ADDR_W(17), .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC), .AUTO_EN_INIT(1'b1)
  ) i_nv_cmd_sequencer (
    .clk(clk), .rstN(rstN), .addr(addr), .rdStb(rdStb), .wrStb(wrStb),
    .supplyOk(supplyOk), .hwReqN(hwReqN), .busyN(busyN), .accessBlock(accessBlock),
    .wrInhibit(wrInhibit), .storeGo(storeGo), .recallGo(recallGo), .autoStoreEn(autoStoreEn)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [16:0] a);
    @(negedge clk); addr = a; rdStb = 1'b1; wrStb = 1'b0;
  endtask

  task automatic wr(input logic [16:0] a);
    @(negedge clk); addr = a; wrStb = 1'b1; rdStb = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk); rdStb = 1'b0; wrStb = 1'b0; #1;
  endtask

  task automatic keyRun(input logic [15:0] op, input logic hi);
    rd({hi, 16'h4E38}); rd({hi, 16'hB1C7}); rd({hi, 16'h83E0});
    rd({hi, 16'h7C1F}); rd({hi, 16'h703F}); rd({hi, op});
    idle();
  endtask

  task automatic waitFree(output int n);
    n = 0;
    while (accessBlock && n < 1000) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  // Request line pulse on a clean block: must start no store.
  task automatic hwProbe(input string req);
    @(negedge clk); hwReqN = 1'b0;
    @(negedge clk); #1;
    chk(req, "no store on request without pending write", int'(accessBlock), 0);
    @(negedge clk); hwReqN = 1'b1; #1;
  endtask

  task automatic testReset();
    int n;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "accessBlock in reset", int'(accessBlock), 0);
    chk("R1", "busyN in reset", int'(busyN), 1);
    chk("R1", "storeGo in reset", int'(storeGo), 0);
    chk("R1", "autoStoreEn in reset", int'(autoStoreEn), 1);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); #1;
    chk("R1", "power-up recallGo", int'(recallGo), 1);
    chk("R1", "busyN during recall", int'(busyN), 1);
    waitFree(n);
    chk("R1", "power-up recall length", n, RECALL_CYC);
  endtask

  task automatic testSoftStore();
    int n;
    keyRun(16'h8FC0, 1'b0);
    chk("R5", "soft store runs with no pending write", int'(storeGo), 1);
    chk("R2", "busyN low at store start", int'(busyN), 0);
    wr(17'h00055); #1;
    chk("R7", "wrInhibit during store", int'(wrInhibit), 1);
    chk("R7", "accessBlock during store", int'(accessBlock), 1);
    idle();
    waitFree(n);
    chk("R2", "store length", n + 2, STORE_CYC);
    hwProbe("R7");
  endtask

  task automatic testAbort();
    int n;
    rd(17'h04E38); rd(17'h0B1C7); rd(17'h083E0);
    wr(17'h00123);
    rd(17'h07C1F); rd(17'h0703F); rd(17'h08FC0);
    idle();
    chk("R3", "write aborts key", int'(storeGo | accessBlock), 0);
    rd(17'h04E38); rd(17'h0B1C7); rd(17'h01234);
    rd(17'h083E0); rd(17'h07C1F); rd(17'h0703F); rd(17'h04C63);
    idle();
    chk("R3", "foreign read aborts key", int'(recallGo | accessBlock), 0);
    rd(17'h04E38);
    keyRun(16'h4C63, 1'b0);
    chk("R3", "restart on first key word then recall", int'(recallGo), 1);
    chk("R2", "busyN high during recall", int'(busyN), 1);
    waitFree(n);
    chk("R2", "recall length", n, RECALL_CYC);
    hwProbe("R10");
  endtask

  task automatic testHwRequest();
    int n;
    @(negedge clk); hwReqN = 1'b0;
    wr(17'h00300); #1;
    chk("R6", "wrInhibit with request low", int'(wrInhibit), 1);
    idle();
    @(negedge clk); hwReqN = 1'b1;
    idle();
    hwProbe("R6");
    wr(17'h00301);
    idle();
    hwReqN = 1'b0;
    @(negedge clk); #1;
    chk("R6", "request starts store when written", int'(storeGo), 1);
    chk("R6", "busyN low", int'(busyN), 0);
    repeat (STORE_CYC + 4) @(negedge clk);
    #1;
    chk("R6", "busyN released after store", int'(busyN), 1);
    chk("R6", "held blocked while request low", int'(accessBlock), 1);
    @(negedge clk); hwReqN = 1'b1;
    @(negedge clk); #1;
    chk("R6", "unblocked after request release", int'(accessBlock), 0);
    n = 0;
    hwProbe("R10");
  endtask

  task automatic testSupply();
    int n;
    wr(17'h00400);
    idle();
    supplyOk = 1'b0;
    @(negedge clk); #1;
    chk("R8", "low supply starts store", int'(storeGo), 1);
    chk("R8", "wrInhibit on low supply", int'(wrInhibit), 1);
    waitFree(n);
    chk("R8", "autostore length", n, STORE_CYC);
    chk("R8", "no recall while supply low", int'(recallGo), 0);
    wr(17'h00401); #1;
    chk("R8", "write inhibited on low supply", int'(wrInhibit), 1);
    idle();
    supplyOk = 1'b1;
    @(negedge clk); #1;
    chk("R8", "recall on supply return", int'(recallGo), 1);
    waitFree(n);
    chk("R8", "recall length after supply return", n, RECALL_CYC);
    hwProbe("R8");
  endtask

  task automatic testInhibit();
    int n;
    keyRun(16'h8B45, 1'b1);
    chk("R4", "key with addr[16] set accepted", int'(autoStoreEn), 0);
    chk("R9", "inhibit clears autoStoreEn", int'(autoStoreEn), 0);
    wr(17'h00500);
    idle();
    supplyOk = 1'b0; hwReqN = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R9", "no autostore when inhibited", int'(accessBlock), 0);
    chk("R8", "request ignored on low supply", int'(storeGo), 0);
    @(negedge clk); supplyOk = 1'b1; hwReqN = 1'b1;
    @(negedge clk); #1;
    chk("R8", "recall after supply dip", int'(recallGo), 1);
    waitFree(n);
    chk("R9", "inhibit kept through supply dip", int'(autoStoreEn), 0);
    keyRun(16'h4B46, 1'b0);
    chk("R9", "re-enable sets autoStoreEn", int'(autoStoreEn), 1);
    wr(17'h00501);
    idle();
    supplyOk = 1'b0;
    @(negedge clk); #1;
    chk("R9", "autostore resumes after re-enable", int'(storeGo), 1);
    waitFree(n);
    supplyOk = 1'b1;
    @(negedge clk); #1;
    waitFree(n);
    chk("R9", "recall length at end", n, RECALL_CYC);
  endtask

  initial begin
    testReset();
    testSoftStore();
    testAbort();
    testHwRequest();
    testSupply();
    testInhibit();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule